// File: doc/BRIEF.md
# Serial normalized min-sum check node processor

This block performs the check-node update of a layered LDPC decoder for a single parity check. The edges of the check arrive one after another. For each edge the block gets the current soft-output value of its variable node and the check-to-variable message that this check sent to that node on the previous pass. The block subtracts the old message to form the variable-to-check message and keeps that message in a small edge buffer. While the edges stream in, it also accumulates the sign parity and the two smallest magnitudes.

Once the last edge has been read, the block plays the edges back in the order they arrived. Each output beat carries the new check-to-variable message, which the caller stores for the next pass, and the updated soft-output value, which the caller writes back. Magnitudes follow the min-sum rule and are scaled by three quarters. Both the subtract and the add saturate instead of wrapping. The surrounding decoder owns the soft-output memory, the message memory, the shifters and the layer schedule.

Top module: `cnp_serial_minsum`

## Requirements
- R1: After reset, `wr_valid_o` and `wr_last_o` are low, and they stay low until a check has been read in completely.
- R2: On each accepted read beat the variable-to-check message is sat(so_i − c), where c is the old message decoded from `c2v_i`. Bit 6 of `c2v_i` is the sign (1 means negative) and bits 5:0 are the magnitude. sat() clamps to the 7-bit signed range [−64, 63].
- R3: The sign bit (bit 6) of each `c2v_o` is the XOR of the signs of all other edges' variable-to-check messages. A message is negative when it is below zero; zero counts as positive.
- R4: Before scaling, the magnitude for an edge is the smallest |variable-to-check| among the other edges of the check, each magnitude first clipped to 63. When several edges tie for the minimum, every edge sees that tied value. A check of degree 1 uses 63.
- R5: The scaled magnitude in `c2v_o` bits 5:0 is m − ⌊m/4⌋, where m is the magnitude from R4.
- R6: `so_o` is sat(v + c'), where v is the edge's variable-to-check message and c' is the signed value of `c2v_o`. It saturates to [−64, 63] and never wraps.
- R7: The write phase starts in the cycle after the beat with `rd_last_i` is accepted. It presents one edge per cycle, with `wr_valid_o` high, in read order. `wr_last_o` marks the final edge, and the block is ready to read again in the next cycle.
- R8: The read phase ends on its own after MAX_DEG accepted beats, even if `rd_last_i` was never asserted.
- R9: Cycles with `rd_valid_i` low in the read phase are skipped; they do not change the result or the edge order.
- R10: Any input asserted during the write phase is ignored, and the outputs of the check being written are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_valid_i | input | 1 | Read beat valid |
| rd_last_i | input | 1 | Marks the last edge of the check |
| so_i | input | 7 | Current soft-output value, two's complement |
| c2v_i | input | 7 | Previous check-to-variable message, sign and magnitude |
| wr_valid_o | output | 1 | Write beat valid |
| wr_last_o | output | 1 | Final edge of the write phase |
| so_o | output | 7 | Updated soft-output value, two's complement |
| c2v_o | output | 7 | New check-to-variable message, sign and magnitude |

## Verification
Three situations are hard to reach from the ports: a read phase that ends at full depth without an end marker, a tie between minimum magnitudes, and saturation in both adders on the same edge. The stimulus reaches them on purpose. One check is 32 edges long with `rd_last_i` held low. Other checks repeat a single magnitude, and others pair extreme soft values with full-scale old messages of opposite sign. Random checks of random degree follow. Some of them have idle gaps in the read phase, and some drive junk inputs throughout the write phase. A behavioural model of the edge list predicts every output cycle.

// File: rtl/cnp_pkg.sv
`timescale 1ns/1ps
package cnp_pkg;
  parameter int SO_W  = 7;
  parameter int MAG_W = 6;

  typedef logic signed [SO_W-1:0] so_t;
  typedef logic [MAG_W-1:0]       mag_t;
  typedef struct packed {
    logic sgn;
    mag_t mag;
  } c2v_t;

  function automatic logic signed [SO_W:0] ext(so_t x);
    return {x[SO_W-1], x};
  endfunction

  function automatic so_t sat(logic signed [SO_W:0] x);
    if (x[SO_W] != x[SO_W-1])
      return x[SO_W] ? {1'b1, {(SO_W-1){1'b0}}} : {1'b0, {(SO_W-1){1'b1}}};
    return x[SO_W-1:0];
  endfunction

  function automatic logic signed [SO_W:0] c2v_val(c2v_t c);
    logic signed [SO_W:0] m;
    m = signed'((SO_W+1)'(c.mag));
    return c.sgn ? -m : m;
  endfunction

  function automatic mag_t abs_clip(so_t v);
    logic [SO_W-1:0] a;
    a = v[SO_W-1] ? unsigned'(-v) : unsigned'(v);
    if (a[SO_W-1:MAG_W] != '0) return '1;
    return a[MAG_W-1:0];
  endfunction

  // scale by 3/4
  function automatic mag_t norm(mag_t x);
    return x - (x >> 2);
  endfunction
endpackage

// File: rtl/cnp_v2c_buf.sv
`timescale 1ns/1ps
module cnp_v2c_buf #(
  parameter int DEPTH = 32,
  parameter int W     = 7,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cnp_min2.sv
`timescale 1ns/1ps
module cnp_min2 import cnp_pkg::*; #(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             first_i,
  input  mag_t             mag_i,
  input  logic             sgn_i,
  input  logic [IDX_W-1:0] idx_i,
  output mag_t             min1_o,
  output mag_t             min2_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             par_o
);
  mag_t             min1_q, min2_q;
  logic [IDX_W-1:0] idx_q;
  logic             par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min1_q <= '1;
      min2_q <= '1;
      idx_q  <= '0;
      par_q  <= 1'b0;
    end else if (en_i) begin
      if (first_i) begin
        min1_q <= mag_i;
        min2_q <= '1;
        idx_q  <= idx_i;
        par_q  <= sgn_i;
      end else begin
        par_q <= par_q ^ sgn_i;
        // strict compare: earliest of tied minima keeps the first slot
        if (mag_i < min1_q) begin
          min2_q <= min1_q;
          min1_q <= mag_i;
          idx_q  <= idx_i;
        end else if (mag_i < min2_q) begin
          min2_q <= mag_i;
        end
      end
    end
  end

  assign min1_o = min1_q;
  assign min2_o = min2_q;
  assign idx_o  = idx_q;
  assign par_o  = par_q;

  p_min_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min1_q <= min2_q);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(min1_q) && $stable(min2_q) && $stable(par_q));
endmodule

// File: rtl/cnp_out.sv
`timescale 1ns/1ps
module cnp_out import cnp_pkg::*; #(
  parameter int IDX_W = 5
) (
  input  so_t              v2c_i,
  input  logic [IDX_W-1:0] idx_i,
  input  mag_t             min1_i,
  input  mag_t             min2_i,
  input  logic [IDX_W-1:0] min_idx_i,
  input  logic             par_i,
  output c2v_t             c2v_o,
  output so_t              so_o
);
  mag_t sel;
  c2v_t c2v_new;

  always_comb begin
    sel         = (idx_i == min_idx_i) ? min2_i : min1_i;
    c2v_new.mag = norm(sel);
    c2v_new.sgn = par_i ^ v2c_i[SO_W-1];
  end

  assign c2v_o = c2v_new;
  assign so_o  = sat(ext(v2c_i) + c2v_val(c2v_new));
endmodule

// File: rtl/cnp_serial_minsum.sv
`timescale 1ns/1ps
module cnp_serial_minsum import cnp_pkg::*; #(
  parameter int MAX_DEG = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_valid_i,
  input  logic             rd_last_i,
  input  logic [SO_W-1:0]  so_i,
  input  logic [MAG_W:0]   c2v_i,
  output logic             wr_valid_o,
  output logic             wr_last_o,
  output logic [SO_W-1:0]  so_o,
  output logic [MAG_W:0]   c2v_o
);
  localparam int   IDX_W  = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1;
  localparam mag_t MAG_MX = '1;
  localparam mag_t NM_MAX = MAG_MX - (MAG_MX >> 2);

  typedef enum logic {ST_RD, ST_WR} st_e;

  st_e              state_q;
  logic [IDX_W-1:0] cnt_q, widx_q, last_idx_q;

  logic             acc, end_rd;
  c2v_t             c2v_in, c2v_new;
  so_t              so_in, v2c_in, wr_v2c, so_new;
  mag_t             min1, min2;
  logic [IDX_W-1:0] min_idx;
  logic             par;

  assign so_in  = so_i;
  assign c2v_in = c2v_i;
  assign acc    = rd_valid_i && (state_q == ST_RD);
  assign end_rd = acc && (rd_last_i || cnt_q == IDX_W'(MAX_DEG-1));
  assign v2c_in = sat(ext(so_in) - c2v_val(c2v_in));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RD;
      cnt_q      <= '0;
      widx_q     <= '0;
      last_idx_q <= '0;
    end else if (state_q == ST_RD) begin
      if (end_rd) begin
        state_q    <= ST_WR;
        last_idx_q <= cnt_q;
        cnt_q      <= '0;
        widx_q     <= '0;
      end else if (acc) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (widx_q == last_idx_q) state_q <= ST_RD;
      else                      widx_q  <= widx_q + 1'b1;
    end
  end

  cnp_v2c_buf #(.DEPTH(MAX_DEG), .W(SO_W)) u_buf (
    .clk_i   (clk_i),
    .we_i    (acc),
    .waddr_i (cnt_q),
    .wdata_i (v2c_in),
    .raddr_i (widx_q),
    .rdata_o (wr_v2c)
  );

  cnp_min2 #(.IDX_W(IDX_W)) u_min (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (acc),
    .first_i (cnt_q == '0),
    .mag_i   (abs_clip(v2c_in)),
    .sgn_i   (v2c_in[SO_W-1]),
    .idx_i   (cnt_q),
    .min1_o  (min1),
    .min2_o  (min2),
    .idx_o   (min_idx),
    .par_o   (par)
  );

  cnp_out #(.IDX_W(IDX_W)) u_out (
    .v2c_i     (wr_v2c),
    .idx_i     (widx_q),
    .min1_i    (min1),
    .min2_i    (min2),
    .min_idx_i (min_idx),
    .par_i     (par),
    .c2v_o     (c2v_new),
    .so_o      (so_new)
  );

  assign wr_valid_o = (state_q == ST_WR);
  assign wr_last_o  = wr_valid_o && (widx_q == last_idx_q);
  assign so_o       = so_new;
  assign c2v_o      = c2v_new;

  p_sub_sat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !so_i[SO_W-1] && c2v_i[MAG_W]) |-> $signed(v2c_in) >= $signed(so_i));

  p_mag_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> c2v_o[MAG_W-1:0] <= NM_MAX);

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_v2c[SO_W-1] && !c2v_o[MAG_W]) |-> $signed(so_o) >= $signed(wr_v2c));

  p_wr_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && rd_last_i) |=> wr_valid_o);

  p_wr_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_last_o |=> !wr_valid_o);

  p_force_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cnt_q == IDX_W'(MAX_DEG-1)) |=> wr_valid_o);

  p_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_last_o) |=> wr_valid_o && $stable(last_idx_q));
endmodule

// File: tb/cnp_serial_minsum_tb_top.sv
`timescale 1ns/1ps
module cnp_serial_minsum_tb_top;
  localparam int MAXD = 32;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_valid_i = 1'b0, rd_last_i = 1'b0;
  logic [6:0] so_i = '0, c2v_i = '0;
  logic       wr_valid_o, wr_last_o;
  logic [6:0] so_o, c2v_o;

  int    checks = 0, errors = 0;
  bit    done = 0;
  string tst = "";

  int so_a[MAXD], cs_a[MAXD], cm_a[MAXD];

  always #10 clk = ~clk;

  cnp_serial_minsum #(.MAX_DEG(MAXD)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rd_valid_i(rd_valid_i), .rd_last_i(rd_last_i),
    .so_i(so_i), .c2v_i(c2v_i), .wr_valid_o(wr_valid_o), .wr_last_o(wr_last_o),
    .so_o(so_o), .c2v_o(c2v_o)
  );

  function automatic int sat7(int x);
    if (x > 63) return 63;
    if (x < -64) return -64;
    return x;
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] act=%0d exp=%0d", rq, tst, act, exp);
    end
  endtask

  task automatic idle_chk();
    chk(wr_valid_o == 1'b0, "R7 no write during read", int'(wr_valid_o), 0);
  endtask

  task automatic set_e(int k, int s, int sg, int m);
    so_a[k] = s; cs_a[k] = sg; cm_a[k] = m;
  endtask

  task automatic run_check(int deg, bit use_last, int gap_pct, bit junk);
    int v[MAXD], mg[MAXD], sg[MAXD], e_so[MAXD], e_sg[MAXD], e_mg[MAXD];
    for (int j = 0; j < deg; j++) begin
      v[j]  = sat7(so_a[j] - (cs_a[j] != 0 ? -cm_a[j] : cm_a[j]));
      mg[j] = (v[j] < 0) ? -v[j] : v[j];
      if (mg[j] > 63) mg[j] = 63;
      sg[j] = (v[j] < 0) ? 1 : 0;
    end
    for (int k = 0; k < deg; k++) begin
      int om = 63, p = 0, nm;
      for (int j = 0; j < deg; j++) if (j != k) begin
        if (mg[j] < om) om = mg[j];
        p ^= sg[j];
      end
      nm = om - om / 4;
      e_sg[k] = p; e_mg[k] = nm;
      e_so[k] = sat7(v[k] + (p != 0 ? -nm : nm));
    end
    for (int i = 0; i < deg; i++) begin
      while ($urandom_range(0, 99) < gap_pct) begin
        @(negedge clk); idle_chk();
        rd_valid_i = 1'b0; rd_last_i = $urandom_range(0, 1) == 1;
      end
      @(negedge clk); idle_chk();
      rd_valid_i = 1'b1;
      rd_last_i  = use_last && (i == deg - 1);
      so_i       = 7'(so_a[i]);
      c2v_i      = {cs_a[i] != 0, 6'(cm_a[i])};
    end
    for (int k = 0; k < deg; k++) begin
      @(negedge clk);
      chk(wr_valid_o == 1'b1, "R7 write valid", int'(wr_valid_o), 1);
      chk(wr_last_o == (k == deg - 1), "R7 write last", int'(wr_last_o), int'(k == deg - 1));
      chk(int'($signed(so_o)) == e_so[k], "R2 R6 soft output", int'($signed(so_o)), e_so[k]);
      chk(int'(c2v_o[6]) == e_sg[k], "R3 message sign", int'(c2v_o[6]), e_sg[k]);
      chk(int'(c2v_o[5:0]) == e_mg[k], "R4 R5 message magnitude", int'(c2v_o[5:0]), e_mg[k]);
      if (junk && k < deg - 1) begin
        rd_valid_i = 1'b1; rd_last_i = $urandom_range(0, 1) == 1;
        so_i = 7'($urandom_range(0, 127)); c2v_i = 7'($urandom_range(0, 127));
      end else begin
        rd_valid_i = 1'b0; rd_last_i = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog R7 act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tst = "R1";
    repeat (3) @(negedge clk);
    chk(wr_valid_o == 1'b0, "R1 valid in reset", int'(wr_valid_o), 0);
    chk(wr_last_o == 1'b0, "R1 last in reset", int'(wr_last_o), 0);
    rst_ni = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(wr_valid_o == 1'b0, "R1 idle after reset", int'(wr_valid_o), 0);
    end

    tst = "basic";
    set_e(0, 10, 0, 3); set_e(1, -20, 1, 2); set_e(2, 5, 0, 5); set_e(3, 30, 0, 41);
    run_check(4, 1, 0, 0);

    tst = "R2 R6 saturation";
    set_e(0, -64, 0, 63); set_e(1, 63, 1, 63); set_e(2, -60, 0, 40); set_e(3, 10, 1, 5);
    run_check(4, 1, 0, 0);
    set_e(0, 63, 0, 0); set_e(1, 63, 0, 0); set_e(2, -64, 0, 0);
    run_check(3, 1, 0, 0);

    tst = "R4 ties";
    for (int j = 0; j < 5; j++) set_e(j, 20, 0, 0);
    run_check(5, 1, 0, 0);
    set_e(0, 9, 0, 0); set_e(1, -30, 0, 0); set_e(2, -9, 0, 0); set_e(3, 9, 1, 0);
    run_check(4, 1, 0, 0);

    tst = "R4 degree one";
    set_e(0, -7, 0, 3);
    run_check(1, 1, 0, 0);

    tst = "R9 gaps";
    for (int j = 0; j < 6; j++) set_e(j, $urandom_range(0, 127) - 64, $urandom_range(0, 1), $urandom_range(0, 63));
    run_check(6, 1, 60, 0);

    tst = "R10 junk in write";
    for (int j = 0; j < 8; j++) set_e(j, $urandom_range(0, 127) - 64, $urandom_range(0, 1), $urandom_range(0, 63));
    run_check(8, 1, 0, 1);

    tst = "R8 full depth";
    for (int j = 0; j < MAXD; j++) set_e(j, $urandom_range(0, 127) - 64, $urandom_range(0, 1), $urandom_range(0, 63));
    run_check(MAXD, 0, 0, 1);
    tst = "R8 after full depth";
    set_e(0, 1, 0, 1); set_e(1, -2, 1, 0);
    run_check(2, 1, 0, 0);

    tst = "random";
    for (int n = 0; n < 150; n++) begin
      int d;
      bit ul;
      d  = $urandom_range(1, MAXD);
      ul = (d < MAXD) || ($urandom_range(0, 1) == 1);
      for (int j = 0; j < d; j++)
        set_e(j, $urandom_range(0, 127) - 64, $urandom_range(0, 1), $urandom_range(0, 63));
      run_check(d, ul, $urandom_range(0, 1) * 30, $urandom_range(0, 1) == 1);
    end

    @(negedge clk); idle_chk();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule